// File: doc/BRIEF.md
# Sixteen-bit timer/counter with capture and reload

This block is a general-purpose up-counter for a peripheral subsystem. In timer operation it advances once per peripheral clock. In event operation it counts falling edges on a count pin. That pin is sampled only when the machine-cycle enable input is high. A second pin, the trigger pin, uses the same sampler. When enabled, a falling edge on it either copies the running count into a capture register or loads the count from a reload register.

Wrapping past the all-ones value raises an overflow flag. The wrap restarts the count from the reload register, or from zero when capture is selected. It can also flip a toggle output that a pad may drive. A trigger event raises an external flag. Either flag can drive the interrupt output. Software configures the block through an eight-bit control register. It can also preload the count and the reload value, and it clears flags through a write-one-to-clear strobe.

Top module: `tcx_timer16`

## Requirements
- R1: After reset the count, the capture register, the control register and both flags read 0, the interrupt output is 0 and the toggle output is 1.
- R2: The control register decodes as: bit 7 prescale select (stored only), bit 6 toggle enable, bit 5 interrupt enable, bit 4 PWM select (stored only), bit 3 trigger enable, bit 2 run, bit 1 event select (1 = count pin edges, 0 = every clock), bit 0 capture select (1 = capture, 0 = reload). It reads back exactly as written, and the stored-only bits do not start counting.
- R3: With run = 1 and event select = 0, the count rises by one on every clock. With run = 0 it holds.
- R4: With event select = 1, each cycle with the machine-cycle enable high samples the count pin. A sample of 0 following a stored sample of 1 adds one, visible on the clock after that sampling edge. When run = 0, edges are ignored. The stored sample resets to 0.
- R5: Incrementing from the all-ones value sets the overflow flag. The next count is the reload value when capture select = 0, and 0 when it is 1.
- R6: On each overflow the toggle output inverts when toggle enable = 1. Otherwise it holds.
- R7: The trigger pin is sampled by the same rule as R4. A detected falling edge is a trigger event only when trigger enable = 1, and a trigger event sets the external flag. With trigger enable = 0 the edge changes neither the flag nor the capture register.
- R8: With capture select = 1, a trigger event stores the count held before that clock into the capture register.
- R9: With capture select = 0, a trigger event loads the reload value into the count. This takes precedence over a simultaneous increment.
- R10: The interrupt output is 1 exactly when interrupt enable = 1 and either flag is set.
- R11: Bit 0 of the flag-clear strobe clears the overflow flag, and bit 1 clears the external flag. A set in the same clock wins over the clear.
- R12: A count write takes precedence over every other count update in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_en | input | 1 | Machine-cycle enable; sampling strobe for both pins |
| cfg_we | input | 1 | Control register write strobe |
| cfg_data | input | 8 | Control register write data |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | W (16) | Count write data |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | W (16) | Reload register write data |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 external |
| cnt_pin | input | 1 | Event count pin |
| trg_pin | input | 1 | Capture/reload trigger pin |
| ctrl_q | output | 8 | Control register contents |
| count_q | output | W (16) | Running count |
| capture_q | output | W (16) | Capture register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External trigger flag |
| irq_o | output | 1 | Interrupt request |
| toggle_o | output | 1 | Overflow toggle output |

## Verification
The bench builds the block with the default width of 16 bits. It uses the count write port to place the counter one or two steps below the all-ones value, so the wrap, the reload-versus-zero restart and the toggle are reached within a few clocks. The bench drives the machine-cycle enable itself, one clock in every two. This makes the cycle in which a sampled edge lands in the count fully determined. That timing lets the bench collide a count edge with a trigger edge, and a count write with a trigger reload, in the same clock.

// File: rtl/tcx_pkg.sv
package tcx_pkg;
  localparam int CTRL_W = 8;

  // Bit positions are decoded by software, so they are fixed.
  localparam int B_PSEL = 7;
  localparam int B_TOG  = 6;
  localparam int B_IRQ  = 5;
  localparam int B_PWM  = 4;
  localparam int B_TRG  = 3;
  localparam int B_RUN  = 2;
  localparam int B_EVT  = 1;
  localparam int B_CAP  = 0;

  typedef struct packed {
    logic psel;
    logic tog_en;
    logic irq_en;
    logic pwm;
    logic trg_en;
    logic run;
    logic evt_sel;
    logic cap_sel;
  } ctrl_t;

  localparam int NFLAG    = 2;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_EXT = 1;
endpackage

// File: rtl/tcx_fall_det.sv
module tcx_fall_det #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mc_en,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] fall_o
);
  logic [NPIN-1:0] smp_q;

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     smp_q[i] <= 1'b0;
        else if (mc_en) smp_q[i] <= pin_i[i];
      end
      // Previous sample high, present sample low, on a sampling cycle.
      assign fall_o[i] = mc_en & smp_q[i] & ~pin_i[i];
    end
  endgenerate
endmodule

// File: rtl/tcx_ctrl_reg.sv
module tcx_ctrl_reg
  import tcx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_data,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_o <= '0;
    else if (cfg_we) ctrl_o <= ctrl_t'(cfg_data);
  end
endmodule

// File: rtl/tcx_count_core.sv
module tcx_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_ev,
  input  logic         trg_ev,
  input  logic         cap_sel,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  output logic [W-1:0] count_q,
  output logic [W-1:0] capture_q,
  output logic [W-1:0] reload_q,
  output logic         ovf_ev
);
  localparam logic [W-1:0] ZERO = '0;

  // One step up; the top bit of the result is the wrap carry.
  function automatic logic [W:0] step_up(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  // Restart value after a wrap: reload in reload mode, zero in capture mode.
  function automatic logic [W-1:0] restart(input logic cap, input logic [W-1:0] rld);
    return cap ? ZERO : rld;
  endfunction

  logic [W:0]   stepped;
  logic [W-1:0] count_d;
  logic         trg_reload;

  assign stepped    = step_up(count_q);
  assign ovf_ev     = inc_ev & stepped[W];
  assign trg_reload = trg_ev & ~cap_sel;

  always_comb begin
    count_d = count_q;
    if (cnt_we)          count_d = cnt_wdata;
    else if (trg_reload) count_d = reload_q;
    else if (ovf_ev)     count_d = restart(cap_sel, reload_q);
    else if (inc_ev)     count_d = stepped[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      capture_q <= '0;
      reload_q  <= '0;
    end else begin
      count_q <= count_d;
      if (trg_ev & cap_sel) capture_q <= count_q;
      if (rld_we)           reload_q  <= rld_wdata;
    end
  end
endmodule

// File: rtl/tcx_flag_unit.sv
module tcx_flag_unit
  import tcx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic             irq_en,
  input  logic             tog_en,
  output logic [NFLAG-1:0] flag_q,
  output logic             irq_o,
  output logic             toggle_o
);
  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q[i] <= 1'b0;
        else if (set_i[i]) flag_q[i] <= 1'b1;
        else if (clr_i[i]) flag_q[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        toggle_o <= 1'b1;
    else if (set_i[FLAG_OVF] & tog_en) toggle_o <= ~toggle_o;
  end

  assign irq_o = irq_en & (|flag_q);
endmodule

// File: rtl/tcx_timer16.sv
module tcx_timer16
  import tcx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_data,
  input  logic              cnt_we,
  input  logic [W-1:0]      cnt_wdata,
  input  logic              rld_we,
  input  logic [W-1:0]      rld_wdata,
  input  logic [NFLAG-1:0]  flag_clr,
  input  logic              cnt_pin,
  input  logic              trg_pin,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [W-1:0]      count_q,
  output logic [W-1:0]      capture_q,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              irq_o,
  output logic              toggle_o
);
  ctrl_t            ctrl;
  logic [1:0]       fall;
  logic             cnt_fall;
  logic             trg_fall;
  logic             inc_ev;
  logic             trg_ev;
  logic             ovf_ev;
  logic [W-1:0]     reload_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;

  tcx_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .ctrl_o   (ctrl)
  );

  tcx_fall_det #(.NPIN(2)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .mc_en  (mc_en),
    .pin_i  ({trg_pin, cnt_pin}),
    .fall_o (fall)
  );

  // Named internal events, visible to the bound checker.
  assign cnt_fall = fall[0];
  assign trg_fall = fall[1];
  assign inc_ev   = ctrl.run & (ctrl.evt_sel ? cnt_fall : 1'b1);
  assign trg_ev   = ctrl.trg_en & trg_fall;

  tcx_count_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_ev    (inc_ev),
    .trg_ev    (trg_ev),
    .cap_sel   (ctrl.cap_sel),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .rld_we    (rld_we),
    .rld_wdata (rld_wdata),
    .count_q   (count_q),
    .capture_q (capture_q),
    .reload_q  (reload_q),
    .ovf_ev    (ovf_ev)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_OVF] = ovf_ev;
    flag_set[FLAG_EXT] = trg_ev;
  end

  tcx_flag_unit u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (flag_set),
    .clr_i    (flag_clr),
    .irq_en   (ctrl.irq_en),
    .tog_en   (ctrl.tog_en),
    .flag_q   (flag_q),
    .irq_o    (irq_o),
    .toggle_o (toggle_o)
  );

  assign ctrl_q   = ctrl;
  assign ovf_flag = flag_q[FLAG_OVF];
  assign ext_flag = flag_q[FLAG_EXT];
endmodule

// File: rtl/tcx_timer16_chk.sv
module tcx_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [7:0]   ctrl_q,
  input logic         cnt_we,
  input logic [W-1:0] cnt_wdata,
  input logic [1:0]   flag_clr,
  input logic         cnt_fall,
  input logic         trg_ev,
  input logic         ovf_ev,
  input logic [W-1:0] count_q,
  input logic [W-1:0] capture_q,
  input logic [W-1:0] reload_q,
  input logic         ovf_flag,
  input logic         ext_flag,
  input logic         irq_o,
  input logic         toggle_o
);
  logic tog_en, irq_en, trg_en, run, evt_sel, cap_sel, trg_reload;
  assign tog_en     = ctrl_q[6];
  assign irq_en     = ctrl_q[5];
  assign trg_en     = ctrl_q[3];
  assign run        = ctrl_q[2];
  assign evt_sel    = ctrl_q[1];
  assign cap_sel    = ctrl_q[0];
  assign trg_reload = trg_ev & ~cap_sel;

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run & ~evt_sel & ~cnt_we & ~trg_reload & ~ovf_ev |=> count_q == $past(count_q) + 1'b1); // R3
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ~run & ~cnt_we & ~trg_reload |=> $stable(count_q)); // R3
  AST_EVT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sel & ~cnt_fall & ~cnt_we & ~trg_reload |=> $stable(count_q)); // R4
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_flag); // R5
  AST_OVF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev & ~cnt_we & ~trg_ev & ~cap_sel |=> count_q == $past(reload_q)); // R5
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev & tog_en |=> toggle_o != $past(toggle_o)); // R6
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ~(ovf_ev & tog_en) |=> $stable(toggle_o)); // R6
  AST_TRG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ~trg_en |=> ~$rose(ext_flag) && $stable(capture_q)); // R7
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trg_ev & cap_sel |=> capture_q == $past(count_q)); // R8
  AST_TRG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trg_reload & ~cnt_we |=> count_q == $past(reload_q)); // R9
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ~irq_en |-> ~irq_o); // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en & (ovf_flag | ext_flag) |-> irq_o); // R10
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr[0] & ~ovf_ev |=> ~ovf_flag); // R11
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count_q == $past(cnt_wdata)); // R12
endmodule

bind tcx_timer16 tcx_timer16_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_q    (ctrl_q),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .flag_clr  (flag_clr),
  .cnt_fall  (cnt_fall),
  .trg_ev    (trg_ev),
  .ovf_ev    (ovf_ev),
  .count_q   (count_q),
  .capture_q (capture_q),
  .reload_q  (reload_q),
  .ovf_flag  (ovf_flag),
  .ext_flag  (ext_flag),
  .irq_o     (irq_o),
  .toggle_o  (toggle_o)
);

// File: tb/tb_tcx_timer16.sv
module tb_tcx_timer16;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mc_en = 1'b0;
  logic         cfg_we = 1'b0;
  logic [7:0]   cfg_data = '0;
  logic         cnt_we = 1'b0;
  logic [W-1:0] cnt_wdata = '0;
  logic         rld_we = 1'b0;
  logic [W-1:0] rld_wdata = '0;
  logic [1:0]   flag_clr = '0;
  logic         cnt_pin = 1'b1;
  logic         trg_pin = 1'b1;
  logic [7:0]   ctrl_q;
  logic [W-1:0] count_q, capture_q;
  logic         ovf_flag, ext_flag, irq_o, toggle_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcx_timer16 #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rld_we(rld_we), .rld_wdata(rld_wdata),
    .flag_clr(flag_clr), .cnt_pin(cnt_pin), .trg_pin(trg_pin), .ctrl_q(ctrl_q),
    .count_q(count_q), .capture_q(capture_q), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .irq_o(irq_o), .toggle_o(toggle_o)
  );

  // Count pin level per machine cycle, and the count expected afterwards.
  localparam logic [16:0] VEC [10] = '{
    {1'b1, 16'd0}, {1'b0, 16'd1}, {1'b0, 16'd1}, {1'b1, 16'd1}, {1'b0, 16'd2},
    {1'b1, 16'd2}, {1'b1, 16'd2}, {1'b0, 16'd3}, {1'b1, 16'd3}, {1'b0, 16'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    cfg_we = 1'b1; cfg_data = v; tick(1); cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [W-1:0] v);
    cnt_we = 1'b1; cnt_wdata = v; tick(1); cnt_we = 1'b0;
  endtask

  task automatic wr_rld(input logic [W-1:0] v);
    rld_we = 1'b1; rld_wdata = v; tick(1); rld_we = 1'b0;
  endtask

  task automatic clr(input logic [1:0] v);
    flag_clr = v; tick(1); flag_clr = '0;
  endtask

  // One machine cycle: sampling clock, then one idle clock.
  task automatic mcycle(input logic cp, input logic tp);
    cnt_pin = cp; trg_pin = tp; mc_en = 1'b1;
    tick(1);
    mc_en = 1'b0;
    tick(1);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tick(1);
    do_reset();
    // R1: reset state
    chk("R1 count", count_q, 0);
    chk("R1 capture", capture_q, 0);
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 flags", {ovf_flag, ext_flag}, 0);
    chk("R1 toggle", toggle_o, 1);
    chk("R1 irq", irq_o, 0);

    // R2: readback, stored-only bits do not run the counter
    wr_ctrl(8'h90);
    tick(3);
    chk("R2 readback", ctrl_q, 8'h90);
    chk("R2 no run", count_q, 0);

    // R3: timer mode
    wr_ctrl(8'h04);
    tick(5);
    chk("R3 five clocks", count_q, 5);
    wr_ctrl(8'h00);
    tick(3);
    chk("R3 stopped", count_q, 6);

    // R4: event mode, table walk
    do_reset();
    wr_ctrl(8'h06);
    for (int i = 0; i < 10; i++) begin
      mcycle(VEC[i][16], 1'b1);
      chk($sformatf("R4 vec%0d", i), count_q, VEC[i][15:0]);
    end
    wr_ctrl(8'h02);
    mcycle(1'b1, 1'b1);
    mcycle(1'b0, 1'b1);
    chk("R4 edge ignored when stopped", count_q, 4);

    // R5 R6 R10: overflow with reload, toggle and interrupt
    wr_rld(16'h1234);
    wr_cnt(16'hFFFE);
    wr_ctrl(8'h64);
    tick(1);
    chk("R5 before wrap", count_q, 16'hFFFF);
    chk("R5 no flag yet", ovf_flag, 0);
    tick(1);
    chk("R5 reload on wrap", count_q, 16'h1234);
    chk("R5 flag", ovf_flag, 1);
    chk("R6 toggled", toggle_o, 0);
    chk("R10 irq raised", irq_o, 1);
    clr(2'b01);
    chk("R11 cleared", ovf_flag, 0);
    chk("R10 irq dropped", irq_o, 0);

    // R5 capture-mode wrap to zero; R11 set beats clear; R6 hold
    wr_ctrl(8'h01);
    wr_cnt(16'hFFFF);
    wr_ctrl(8'h05);
    clr(2'b01);
    chk("R5 wrap to zero", count_q, 0);
    chk("R11 set wins", ovf_flag, 1);
    chk("R6 toggle held", toggle_o, 0);
    chk("R10 irq masked", irq_o, 0);

    // R8: capture on trigger edge
    wr_ctrl(8'h0F);
    wr_cnt(16'h00AB);
    mcycle(1'b1, 1'b1);
    mcycle(1'b1, 1'b0);
    chk("R8 captured", capture_q, 16'h00AB);
    chk("R7 ext flag", ext_flag, 1);
    chk("R8 count kept", count_q, 16'h00AB);

    // R7: trigger disabled
    clr(2'b10);
    wr_ctrl(8'h07);
    wr_cnt(16'h0055);
    mcycle(1'b1, 1'b1);
    mcycle(1'b1, 1'b0);
    chk("R7 capture unchanged", capture_q, 16'h00AB);
    chk("R7 no ext flag", ext_flag, 0);

    // R9: reload on trigger, then against a simultaneous count edge
    wr_rld(16'h0500);
    wr_ctrl(8'h0E);
    wr_cnt(16'h0010);
    mcycle(1'b1, 1'b1);
    mcycle(1'b1, 1'b0);
    chk("R9 reload", count_q, 16'h0500);
    chk("R9 ext flag", ext_flag, 1);
    wr_cnt(16'h0010);
    mcycle(1'b1, 1'b1);
    mcycle(1'b0, 1'b0);
    chk("R9 reload beats increment", count_q, 16'h0500);

    // R12: count write beats a trigger reload
    mcycle(1'b1, 1'b1);
    cnt_we = 1'b1; cnt_wdata = 16'h0777;
    trg_pin = 1'b0; mc_en = 1'b1;
    tick(1);
    cnt_we = 1'b0; mc_en = 1'b0;
    chk("R12 write wins", count_q, 16'h0777);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule